// File: doc/BRIEF.md
# Polled Pseudo-Random Word Generator

This block is a 32-bit register peripheral that a processor drives purely by polling. Software loads five seed words, selects the pseudo-random engine and issues a start command through the control register. The block then runs a fixed-length generation burst and publishes five fresh 32-bit output words, raising a completion flag in the status register. Software polls status, reads the words, and clears the flag by writing status back.

Every seed word has its own "written" flag, and a seed-complete status bit is raised only once all five have been loaded. Each output lane is a 32-bit xorshift state (shifts 13 left, 17 right, 5 left), loaded directly from its seed word. A lane whose seed is zero is loaded with 32'h9E3779B9 instead. Lanes keep their state between bursts, so repeated starts keep producing new values.

The register port takes one access in every clock cycle and never stalls, so it has no ready signal and no back-pressure. A read request yields exactly one response on `rsp_valid`/`rsp_data` in the following cycle. Offsets that matter to software: control 0x000, status 0x010, seed word n at 0x140+4n, output word n at 0x160+4n (n = 0..4), all inside a 0x200-byte window.

Top module: `prng_regblock`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x1 and all five output words read 0; all seed-written flags are clear.
- R2: Status bit 1 (seed complete) is 1 only once every one of the five seed words (0x140..0x150) has been written since reset; writing the same seed word again keeps its flag set.
- R3: Seed words read back as 0. A seed value of 0 loads that lane with 32'h9E3779B9.
- R4: A control write starts generation only when status bit 1 is 1 and the written value has both bit 3 (engine select) and bit 4 (start) set. Otherwise the output words do not change.
- R5: After any accepted control write, control bit 4 reads 0 and every other bit reads as written.
- R6: A started burst keeps status bit 2 (busy) at 1 for exactly 8 cycles. The output words keep their old values during that time. At the end each output word equals its lane state advanced 8 xorshift steps, and status bit 5 (done) becomes 1.
- R7: A control write that arrives while busy is 1 is ignored.
- R8: A status write sets bits 5, 4 and 3 to the written values and leaves every other status bit unchanged. Bit 0 is always 1 and bit 7 is always 0.
- R9: A read of any unmapped or misaligned offset returns 0, and a write to one changes no register.
- R10: rsp_valid is 1 in the cycle after each read request and only then, and rsp_data carries the register value from the request cycle.
- R11: A second burst continues from the lane states the first one left behind, so after two bursts the output equals the seed advanced 16 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 32 | Read response data |

## Verification
The bench builds the block with its default parameters: five seed and output lanes, an 8-cycle burst and a 9-bit offset. With five lanes the bench must load every seed slot, and the zero-seed substitute can be checked on the last lane. An 8-cycle burst is short enough to poll status on every cycle of it, so the first and last busy cycles, and the ignored control write that falls inside the burst, are all observed directly. A second burst then checks that the lane states carry on from the first.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int WORD_W = 32;

  // register offsets (bytes)
  localparam int OFF_CTRL = 'h000;
  localparam int OFF_STAT = 'h010;
  localparam int OFF_SEED = 'h140;
  localparam int OFF_OUT  = 'h160;
  localparam int STRIDE   = 4;

  // control bit positions
  localparam int CTL_SEL   = 3;
  localparam int CTL_START = 4;

  // status bit positions
  localparam int ST_READY   = 0;
  localparam int ST_SEEDED  = 1;
  localparam int ST_BUSY    = 2;
  localparam int ST_PART    = 3;
  localparam int ST_MSG     = 4;
  localparam int ST_DONE    = 5;
  localparam int ST_ERR     = 7;

  localparam logic [WORD_W-1:0] ZERO_SUB = 32'h9E37_79B9;

  function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/prng_seed_track.sv
module prng_seed_track #(
  parameter int NUM_WORDS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WORDS-1:0] wr_hit,
  output logic                 all_set
);
  logic [NUM_WORDS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_q | wr_hit;
  end

  assign all_set = &flags_q;
endmodule

// File: rtl/prng_lane.sv
module prng_lane
  import prng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] state_q;

  assign nxt = xs_step(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= ZERO_SUB;
    else if (load) state_q <= (load_val == '0) ? ZERO_SUB : load_val;
    else if (step) state_q <= nxt;
  end
endmodule

// File: rtl/prng_seq.sv
module prng_seq #(
  parameter int GEN_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = (GEN_CYCLES > 1) ? $clog2(GEN_CYCLES) : 1;
  logic [CW-1:0] cnt_q;

  assign finish = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(GEN_CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/prng_regblock.sv
module prng_regblock
  import prng_pkg::*;
#(
  parameter int NUM_WORDS  = 5,
  parameter int GEN_CYCLES = 8,
  parameter int ADDR_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);
  localparam int W = WORD_W;

  // ---------------- decode ----------------
  logic hit_ctl, hit_stat;
  logic [NUM_WORDS-1:0] hit_seed, hit_out;

  assign hit_ctl  = bus_valid && (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = bus_valid && (bus_addr == ADDR_W'(OFF_STAT));

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_dec
    assign hit_seed[n] = bus_valid && (bus_addr == ADDR_W'(OFF_SEED + STRIDE * n));
    assign hit_out[n]  = bus_valid && (bus_addr == ADDR_W'(OFF_OUT + STRIDE * n));
  end

  logic ctl_wr, stat_wr, rd_req;
  logic [NUM_WORDS-1:0] seed_wr;
  assign ctl_wr  = hit_ctl && bus_write;
  assign stat_wr = hit_stat && bus_write;
  assign seed_wr = hit_seed & {NUM_WORDS{bus_write}};
  assign rd_req  = bus_valid && !bus_write;

  // ---------------- seed bookkeeping ----------------
  logic seed_all;
  prng_seed_track #(.NUM_WORDS(NUM_WORDS)) u_track (
    .clk(clk), .rst_n(rst_n), .wr_hit(seed_wr), .all_set(seed_all)
  );

  // ---------------- sequencer ----------------
  logic busy, finish, start;
  assign start = ctl_wr && !busy && seed_all &&
                 bus_wdata[CTL_SEL] && bus_wdata[CTL_START];

  prng_seq #(.GEN_CYCLES(GEN_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finish(finish)
  );

  // ---------------- lanes and output words ----------------
  logic [NUM_WORDS-1:0][W-1:0] lane_nxt;
  logic [NUM_WORDS-1:0][W-1:0] out_q;

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_lane
    prng_lane u_lane (
      .clk(clk), .rst_n(rst_n), .load(seed_wr[n]), .load_val(bus_wdata),
      .step(busy), .nxt(lane_nxt[n])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)      out_q[n] <= '0;
      else if (finish) out_q[n] <= lane_nxt[n];
    end
  end

  // ---------------- control register ----------------
  logic [W-1:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (ctl_wr && !busy)  ctrl_q <= bus_wdata & ~(W'(1) << CTL_START);
  end

  // ---------------- status flags ----------------
  logic done_q, msg_q, part_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      msg_q  <= 1'b0;
      part_q <= 1'b0;
    end else begin
      if (stat_wr) begin
        done_q <= bus_wdata[ST_DONE];
        msg_q  <= bus_wdata[ST_MSG];
        part_q <= bus_wdata[ST_PART];
      end
      if (finish) done_q <= 1'b1;
    end
  end

  logic [W-1:0] status_word;
  always_comb begin
    status_word            = '0;
    status_word[ST_READY]  = 1'b1;
    status_word[ST_SEEDED] = seed_all;
    status_word[ST_BUSY]   = busy;
    status_word[ST_PART]   = part_q;
    status_word[ST_MSG]    = msg_q;
    status_word[ST_DONE]   = done_q;
    status_word[ST_ERR]    = 1'b0;
  end

  // ---------------- read path ----------------
  logic [W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit_ctl)  rd_word = ctrl_q;
    if (hit_stat) rd_word = status_word;
    for (int n = 0; n < NUM_WORDS; n++)
      if (hit_out[n]) rd_word = out_q[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_word;
    end
  end
endmodule

// File: rtl/prng_regblock_chk.sv
module prng_regblock_chk #(
  parameter int NUM_WORDS  = 5,
  parameter int GEN_CYCLES = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ctl_wr,
  input logic                        stat_wr,
  input logic [NUM_WORDS-1:0]        seed_wr,
  input logic                        seed_all,
  input logic                        busy,
  input logic                        done_q,
  input logic [31:0]                 ctrl_q,
  input logic [NUM_WORDS-1:0][31:0]  out_q
);
  int busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  a_r5_start_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctrl_q[4]);

  a_r2_seed_done_from_seed_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_all) |-> $past(|seed_wr));

  a_r6_done_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy) || $past(stat_wr)));

  a_r6_outputs_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(out_q));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= GEN_CYCLES);

  a_r7_ctrl_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(ctrl_q));
endmodule

bind prng_regblock prng_regblock_chk #(
  .NUM_WORDS(NUM_WORDS), .GEN_CYCLES(GEN_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stat_wr(stat_wr),
  .seed_wr(seed_wr), .seed_all(seed_all), .busy(busy), .done_q(done_q),
  .ctrl_q(ctrl_q), .out_q(out_q)
);

// File: tb/sim_prng_regblock.sv
module sim_prng_regblock;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SUB = 32'h9E37_79B9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prng_regblock u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] adv(input logic [31:0] x, input int n);
    logic [31:0] t = x;
    for (int i = 0; i < n; i++) begin
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
    end
    return t;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, input logic [31:0] exp, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    check({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    check(tag, rsp_data, exp);
  endtask

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 9'h000, 32'h0000_0000, 4'd1},   // R1 control reset
    '{1'b0, 9'h010, 32'h0000_0001, 4'd1},   // R1 status reset
    '{1'b0, 9'h160, 32'h0000_0000, 4'd1},   // R1 output 0
    '{1'b0, 9'h170, 32'h0000_0000, 4'd1},   // R1 output 4
    '{1'b1, 9'h140, 32'h0000_0001, 4'd2},   // R2 seed 0
    '{1'b1, 9'h144, 32'h0000_0002, 4'd2},   // R2 seed 1
    '{1'b0, 9'h010, 32'h0000_0001, 4'd2},   // R2 incomplete
    '{1'b1, 9'h148, 32'h0000_0003, 4'd2},   // R2 seed 2
    '{1'b1, 9'h14C, 32'h0000_0004, 4'd2},   // R2 seed 3
    '{1'b1, 9'h14C, 32'h0000_0005, 4'd2},   // R2 rewrite seed 3
    '{1'b0, 9'h010, 32'h0000_0001, 4'd2},   // R2 still four flags
    '{1'b1, 9'h150, 32'h0000_0000, 4'd3},   // R3 zero seed 4
    '{1'b0, 9'h010, 32'h0000_0003, 4'd2},   // R2 complete
    '{1'b0, 9'h140, 32'h0000_0000, 4'd3},   // R3 seed reads 0
    '{1'b0, 9'h150, 32'h0000_0000, 4'd3},   // R3 seed reads 0
    '{1'b1, 9'h000, 32'h0000_0010, 4'd4},   // R4 start without select
    '{1'b0, 9'h000, 32'h0000_0000, 4'd5},   // R5 start bit cleared
    '{1'b0, 9'h010, 32'h0000_0003, 4'd4},   // R4 no burst
    '{1'b0, 9'h160, 32'h0000_0000, 4'd4},   // R4 outputs unchanged
    '{1'b1, 9'h010, 32'hFFFF_FFFF, 4'd8},   // R8 status write all ones
    '{1'b0, 9'h010, 32'h0000_003B, 4'd8},   // R8 only 5,4,3 change
    '{1'b1, 9'h010, 32'h0000_0000, 4'd8},   // R8 clear
    '{1'b0, 9'h010, 32'h0000_0003, 4'd8},   // R8 cleared
    '{1'b1, 9'h004, 32'hFFFF_FFFF, 4'd9},   // R9 unmapped write
    '{1'b0, 9'h004, 32'h0000_0000, 4'd9},   // R9 unmapped read
    '{1'b1, 9'h001, 32'h0000_0018, 4'd9},   // R9 misaligned write
    '{1'b0, 9'h000, 32'h0000_0000, 4'd9},   // R9 control untouched
    '{1'b1, 9'h000, 32'h0000_0008, 4'd4},   // R4 select without start
    '{1'b0, 9'h000, 32'h0000_0008, 4'd5}    // R5 other bits kept
  };

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R6: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seeds [5];
    seeds = '{32'd1, 32'd2, 32'd3, 32'd5, SUB};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: no response without a read
    check("R10 idle", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
      else           do_read(VEC[i].addr, VEC[i].data, $sformatf("R%0d row %0d", VEC[i].req, i));
    end
    // R4: select alone produced nothing
    do_read(9'h160, 32'h0, "R4 select only");

    // R6 / R7: burst, busy window polled each cycle
    do_write(9'h000, 32'h0000_0018);
    for (int k = 1; k <= 9; k++) begin
      if (k == 3) begin
        do_write(9'h000, 32'h0000_0000);  // R7 ignored while busy
      end else if (k == 4) begin
        do_read(9'h160, 32'h0, "R6 outputs held while busy");
      end else begin
        do_read(9'h010, (k <= 8) ? 32'h07 : 32'h23, $sformatf("R6 busy cycle %0d", k));
      end
    end
    do_read(9'h000, 32'h0000_0008, "R7 control unchanged");
    for (int n = 0; n < 5; n++)
      do_read(9'(9'h160 + 4 * n), adv(seeds[n], 8), $sformatf("R6 output %0d", n));
    check("R3 zero seed lane", adv(seeds[4], 0), SUB);

    // R10: no response after write
    do_write(9'h010, 32'h0);
    check("R10 write gives no response", {31'b0, rsp_valid}, 32'd0);

    // R11: second burst continues
    do_write(9'h000, 32'h0000_0018);
    repeat (10) @(negedge clk);
    do_read(9'h160, adv(seeds[0], 16), "R11 output 0");
    do_read(9'h170, adv(seeds[4], 16), "R11 output 4");

    // R1 / R2 / R4: reset mid-state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(9'h000, 32'h0, "R1 control after reset");
    do_read(9'h010, 32'h1, "R1 status after reset");
    do_read(9'h164, 32'h0, "R1 output after reset");
    for (int n = 0; n < 4; n++) do_write(9'(9'h140 + 4 * n), 32'h77);
    do_read(9'h010, 32'h1, "R2 flags cleared by reset");
    do_write(9'h000, 32'h0000_0018);
    repeat (10) @(negedge clk);
    do_read(9'h160, 32'h0, "R4 no burst with incomplete seed");
    do_write(9'h150, 32'h88);
    do_read(9'h010, 32'h3, "R2 fifth seed completes");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule